// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block generates one pulse-width modulated line per channel, four by default. Software programs it through a small memory-mapped register port with an address, write data, a write strobe, a read strobe and combinational read data. Each channel has a mode word with a power-of-two prescale select and a polarity bit, plus a 16-bit on-time (duty) and a 16-bit cycle length (period). A channel's counter runs at the prescaled rate from zero up to period minus one. The line is active while the count is below the duty, and the polarity bit can invert it.

Channels are started and stopped through two write-one strobe words, one that sets run bits and one that clears them. A third word reads back which channels are running. While a channel is stopped, writes to its duty or period take effect at once. While it runs, those direct words are frozen. New values go to a second pair of update words and are held there until the running cycle ends, so no pulse is ever cut short or lengthened.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: After reset every channel is stopped, the status word (0x00C) reads 0, all mode, duty and period words read 0, and every output is low.
- R2: A write to 0x004 sets the run bit of each channel whose data bit n is 1. Channels whose bit is 0 keep their state.
- R3: A write to 0x008 clears the run bit of each channel whose data bit n is 1. Status bits 3:0 at 0x00C show the run bits, and they change only on writes to 0x004 or 0x008.
- R4: Channel n's words start at 0x200 + n*0x20. The mode word is at +0x00, with the prescale select in bits 3:0 and the polarity in bit 9. A select written above 10 is stored and read back as 10.
- R5: A stopped channel drives its polarity bit as the output level: 0 gives a low line and 1 gives a high line.
- R6: A running channel's count advances once every 2^select clocks and wraps from period-1 to 0. The output equals (count < duty) XOR polarity.
- R7: A duty of 0 gives a constant inactive level. A duty at or above the period gives a constant active level.
- R8: Duty (+0x04) and period (+0x0C) keep only data bits 15:0. When the channel is stopped, writes to them take effect at once. When it is running, writes to them are ignored.
- R9: A write to the duty-update word (+0x08) on a running channel reaches the active duty only when the current cycle wraps. Until then the duty word reads the old value. On a stopped channel the new value applies at once.
- R10: A write to the period-update word (+0x10) follows the same end-of-cycle rule for the period.
- R11: Enabling a stopped channel starts its count and its prescaler at 0. Enabling a channel that is already running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, qualifies rdata_o |
| rdata_o | output | 32 | Read data, combinational, 0 when rd_i is low |
| pwm_o | output | 4 | One modulated line per channel |

## Verification
Some rules are checked by the assertions on every cycle. The run bits change only as the set and clear strobes dictate. A stopped channel, or one with a zero duty, sits at its polarity level. The count stays below a nonzero period. A stored select never exceeds 10. The active duty of a running channel moves only at the point where the count wraps to zero.

Other behaviour can only be shown by the bench's scenarios. These are the exact high-time counts over whole cycles across prescale settings, and the full-on case. They also include the cycle in which a buffered duty or period first takes effect, the ignoring of direct writes while running, and the register readback encoding.

// File: rtl/pwm_mc_pkg.sv
package pwm_mc_pkg;

   // Global word offsets (software decodes these)
   localparam int unsigned OFS_RUN_SET = 'h004;
   localparam int unsigned OFS_RUN_CLR = 'h008;
   localparam int unsigned OFS_RUN_STS = 'h00C;

   // Channel banks
   localparam int unsigned BANK_BASE_SHIFT = 9;   // banks live in 0x200..0x3FF
   localparam int unsigned BANK_IDX_LSB    = 5;   // 0x20 stride
   localparam int unsigned BANK_IDX_W      = 4;

   // Field position of the polarity flag inside the mode word
   localparam int unsigned POL_BIT = 9;

   typedef enum logic [2:0] {
      BREG_NONE,
      BREG_MODE,
      BREG_DUTY,
      BREG_DUTY_NEXT,
      BREG_PER,
      BREG_PER_NEXT
   } bank_reg_e;

   function automatic bank_reg_e decode_bank_reg(input logic [4:0] ofs);
      case (ofs)
         5'h00:   return BREG_MODE;
         5'h04:   return BREG_DUTY;
         5'h08:   return BREG_DUTY_NEXT;
         5'h0C:   return BREG_PER;
         5'h10:   return BREG_PER_NEXT;
         default: return BREG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pwm_mc_prescale.sv
module pwm_mc_prescale #(
   parameter int unsigned PRES_W   = 4,
   parameter int unsigned PRES_MAX = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [PRES_W-1:0] sel_i,
   output logic              tick_o
);

   localparam int unsigned DIV_W = (PRES_MAX > 0) ? PRES_MAX : 1;

   if (PRES_MAX == 0) begin : g_no_div
      logic sel_unused;
      assign sel_unused = ^{sel_i, clk_i, rst_ni};
      assign tick_o     = run_i;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      logic [DIV_W:0]   one_hot;
      logic [DIV_W-1:0] limit;

      always_comb begin
         one_hot = (DIV_W+1)'(1) << sel_i;
         limit   = DIV_W'(one_hot - 1'b1);
      end

      assign tick_o = run_i && (div_q == limit);

      always_ff @(posedge clk_i) begin
         if (!rst_ni || !run_i) begin
            div_q <= '0;
         end else if (tick_o) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwm_mc_bufreg.sv
module pwm_mc_bufreg #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic         wrap_i,
   input  logic         wr_direct_i,
   input  logic         wr_next_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] act_o,
   output logic [W-1:0] next_o
);

   logic pend_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_o  <= '0;
         next_o <= '0;
         pend_q <= 1'b0;
      end else if (wr_direct_i && !run_i) begin
         act_o  <= wdata_i;
         next_o <= wdata_i;
         pend_q <= 1'b0;
      end else if (wr_next_i) begin
         next_o <= wdata_i;
         if (!run_i) begin
            act_o  <= wdata_i;
            pend_q <= 1'b0;
         end else begin
            pend_q <= 1'b1;
         end
      end else if (wrap_i && pend_q) begin
         act_o  <= next_o;
         pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/pwm_mc_channel.sv
module pwm_mc_channel #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRES_W   = 4,
   parameter int unsigned PRES_MAX = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [PRES_W-1:0] sel_i,
   input  logic              pol_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              wr_duty_i,
   input  logic              wr_duty_next_i,
   input  logic              wr_per_i,
   input  logic              wr_per_next_i,
   output logic [CNT_W-1:0]  duty_o,
   output logic [CNT_W-1:0]  duty_next_o,
   output logic [CNT_W-1:0]  per_o,
   output logic [CNT_W-1:0]  per_next_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              pwm_o
);

   logic tick;
   logic last;
   logic wrap;

   pwm_mc_prescale #(.PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .sel_i  (sel_i),
      .tick_o (tick)
   );

   // Wrap when the next count would reach the period (period 0 holds at 0)
   assign last = ({1'b0, cnt_o} + 1'b1) >= {1'b0, per_o};
   assign wrap = run_i && tick && last;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) begin
         cnt_o <= '0;
      end else if (tick) begin
         cnt_o <= last ? '0 : cnt_o + 1'b1;
      end
   end

   pwm_mc_bufreg #(.W(CNT_W)) u_duty (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_i),
      .wrap_i      (wrap),
      .wr_direct_i (wr_duty_i),
      .wr_next_i   (wr_duty_next_i),
      .wdata_i     (wdata_i),
      .act_o       (duty_o),
      .next_o      (duty_next_o)
   );

   pwm_mc_bufreg #(.W(CNT_W)) u_per (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_i),
      .wrap_i      (wrap),
      .wr_direct_i (wr_per_i),
      .wr_next_i   (wr_per_next_i),
      .wdata_i     (wdata_i),
      .act_o       (per_o),
      .next_o      (per_next_o)
   );

   assign pwm_o = run_i ? ((cnt_o < duty_o) ^ pol_i) : pol_i;

endmodule

// File: rtl/pwm_multi_ctrl.sv
module pwm_multi_ctrl
   import pwm_mc_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRES_W   = 4,
   parameter int unsigned PRES_MAX = 10,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [NUM_CH-1:0] pwm_o
);

   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH must lie in 1..16");
   end
   if (CNT_W > DATA_W || NUM_CH > DATA_W || POL_BIT >= DATA_W) begin : g_bad_data
      $error("DATA_W too narrow for the fields");
   end
   if (PRES_MAX >= (1 << PRES_W) || PRES_W > POL_BIT) begin : g_bad_pres
      $error("PRES_W cannot hold PRES_MAX or overlaps the polarity bit");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must be at least 10");
   end

   // Decode
   logic                  hit_set, hit_clr, hit_sts;
   logic                  bank_ok;
   logic [BANK_IDX_W-1:0] bank_idx;
   logic [CH_W-1:0]       ch_sel;
   bank_reg_e             breg;

   always_comb begin
      hit_set  = (addr_i == ADDR_W'(OFS_RUN_SET));
      hit_clr  = (addr_i == ADDR_W'(OFS_RUN_CLR));
      hit_sts  = (addr_i == ADDR_W'(OFS_RUN_STS));
      bank_idx = addr_i[BANK_IDX_LSB +: BANK_IDX_W];
      ch_sel   = bank_idx[CH_W-1:0];
      bank_ok  = (addr_i[ADDR_W-1:BANK_BASE_SHIFT] == (ADDR_W-BANK_BASE_SHIFT)'(1))
                 && (int'(bank_idx) < int'(NUM_CH));
      breg     = decode_bank_reg(addr_i[4:0]);
   end

   // Run bits
   logic [NUM_CH-1:0] run_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (wr_i && hit_set) begin
         run_q <= run_q | wdata_i[NUM_CH-1:0];
      end else if (wr_i && hit_clr) begin
         run_q <= run_q & ~wdata_i[NUM_CH-1:0];
      end
   end

   // Mode write value with clamped select
   logic [PRES_W-1:0] sel_in, sel_wr;
   always_comb begin
      sel_in = wdata_i[PRES_W-1:0];
      sel_wr = (int'(sel_in) > int'(PRES_MAX)) ? PRES_W'(PRES_MAX) : sel_in;
   end

   logic [NUM_CH-1:0][PRES_W-1:0] sel_q;
   logic [NUM_CH-1:0]             pol_q;
   logic [NUM_CH-1:0][CNT_W-1:0]  duty_act, duty_nxt, per_act, per_nxt, cnt_val;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit_ch;
      assign hit_ch = wr_i && bank_ok && (bank_idx == BANK_IDX_W'(g));

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            sel_q[g] <= '0;
            pol_q[g] <= 1'b0;
         end else if (hit_ch && breg == BREG_MODE) begin
            sel_q[g] <= sel_wr;
            pol_q[g] <= wdata_i[POL_BIT];
         end
      end

      pwm_mc_channel #(.CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_chan (
         .clk_i          (clk_i),
         .rst_ni         (rst_ni),
         .run_i          (run_q[g]),
         .sel_i          (sel_q[g]),
         .pol_i          (pol_q[g]),
         .wdata_i        (wdata_i[CNT_W-1:0]),
         .wr_duty_i      (hit_ch && breg == BREG_DUTY),
         .wr_duty_next_i (hit_ch && breg == BREG_DUTY_NEXT),
         .wr_per_i       (hit_ch && breg == BREG_PER),
         .wr_per_next_i  (hit_ch && breg == BREG_PER_NEXT),
         .duty_o         (duty_act[g]),
         .duty_next_o    (duty_nxt[g]),
         .per_o          (per_act[g]),
         .per_next_o     (per_nxt[g]),
         .cnt_o          (cnt_val[g]),
         .pwm_o          (pwm_o[g])
      );
   end

   // Read mux
   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         if (hit_sts) begin
            rdata_o[NUM_CH-1:0] = run_q;
         end else if (bank_ok) begin
            case (breg)
               BREG_MODE: begin
                  rdata_o[PRES_W-1:0] = sel_q[ch_sel];
                  rdata_o[POL_BIT]    = pol_q[ch_sel];
               end
               BREG_DUTY:      rdata_o[CNT_W-1:0] = duty_act[ch_sel];
               BREG_DUTY_NEXT: rdata_o[CNT_W-1:0] = duty_nxt[ch_sel];
               BREG_PER:       rdata_o[CNT_W-1:0] = per_act[ch_sel];
               BREG_PER_NEXT:  rdata_o[CNT_W-1:0] = per_nxt[ch_sel];
               default:        rdata_o = '0;
            endcase
         end
      end
   end

   logic wdata_unused;
   assign wdata_unused = ^wdata_i;

endmodule

// File: rtl/pwm_multi_ctrl_chk.sv
module pwm_multi_ctrl_chk
   import pwm_mc_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRES_W   = 4,
   parameter int unsigned PRES_MAX = 10,
   parameter int unsigned ADDR_W   = 12
) (
   input logic                            clk_i,
   input logic                            rst_ni,
   input logic [ADDR_W-1:0]               addr_i,
   input logic [NUM_CH-1:0]               wbits_i,
   input logic                            wr_i,
   input logic [NUM_CH-1:0]               run_q,
   input logic [NUM_CH-1:0][PRES_W-1:0]   sel_q,
   input logic [NUM_CH-1:0]               pol_q,
   input logic [NUM_CH-1:0][CNT_W-1:0]    duty_act,
   input logic [NUM_CH-1:0][CNT_W-1:0]    per_act,
   input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_val,
   input logic [NUM_CH-1:0]               pwm_o
);

   logic set_wr, clr_wr;
   assign set_wr = wr_i && (addr_i == ADDR_W'(OFS_RUN_SET));
   assign clr_wr = wr_i && (addr_i == ADDR_W'(OFS_RUN_CLR));

   p_run_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_wr |=> ((run_q & $past(wbits_i)) == $past(wbits_i)));

   p_run_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr |=> ((run_q & $past(wbits_i)) == '0));

   p_run_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_wr || clr_wr) |=> $stable(run_q));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      p_sel_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         int'(sel_q[g]) <= int'(PRES_MAX));

      p_idle_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !run_q[g] |-> (pwm_o[g] == pol_q[g]));

      p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (per_act[g] != '0) |-> (cnt_val[g] < per_act[g]));

      p_zero_duty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (duty_act[g] == '0) |-> (pwm_o[g] == pol_q[g]));

      p_duty_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (run_q[g] && $past(run_q[g]) && cnt_val[g] != '0) |-> $stable(duty_act[g]));
   end

endmodule

bind pwm_multi_ctrl pwm_multi_ctrl_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX), .ADDR_W(ADDR_W)
) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .addr_i   (addr_i),
   .wbits_i  (wdata_i[NUM_CH-1:0]),
   .wr_i     (wr_i),
   .run_q    (run_q),
   .sel_q    (sel_q),
   .pol_q    (pol_q),
   .duty_act (duty_act),
   .per_act  (per_act),
   .cnt_val  (cnt_val),
   .pwm_o    (pwm_o)
);

// File: tb/pwm_multi_ctrl_tb_top.sv
module pwm_multi_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic [3:0]  pwm;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pwm_multi_ctrl dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .addr_i  (addr),
      .wdata_i (wdata),
      .wr_i    (wr),
      .rd_i    (rd),
      .rdata_o (rdata),
      .pwm_o   (pwm)
   );

   typedef struct packed {
      logic [3:0]  pres;
      logic        pol;
      logic [15:0] duty;
      logic [15:0] per;
      logic [15:0] high;   // expected high cycles in the window
      logic [15:0] win;    // two full cycles: 2*per*2^pres
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{4'd0,  1'b0, 16'd3, 16'd8,  16'd6,    16'd16},
      '{4'd1,  1'b0, 16'd5, 16'd10, 16'd20,   16'd40},
      '{4'd2,  1'b1, 16'd2, 16'd6,  16'd32,   16'd48},
      '{4'd0,  1'b0, 16'd0, 16'd7,  16'd0,    16'd14},
      '{4'd0,  1'b0, 16'd9, 16'd5,  16'd10,   16'd10},
      '{4'd3,  1'b0, 16'd1, 16'd4,  16'd16,   16'd64},
      '{4'd0,  1'b1, 16'd4, 16'd4,  16'd0,    16'd8},
      '{4'd10, 1'b0, 16'd1, 16'd2,  16'd2048, 16'd4096}
   };

   function automatic logic [11:0] ch_addr(input int ch, input int ofs);
      return 12'(32'h200 + ch * 32'h20 + ofs);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      addr = a; rd = 1'b1;
      #1;
      d = rdata;
      rd = 1'b0;
   endtask

   task automatic count_high(input int ch, input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         if (pwm[ch]) hi++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int hi;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 outputs", pwm, 0);
      bus_rd(12'h00C, d); check("R1 status", d, 0);
      bus_rd(ch_addr(2, 0), d); check("R1 mode", d, 0);
      bus_rd(ch_addr(3, 'h0C), d); check("R1 period", d, 0);

      // R2 set, R3 clear
      bus_wr(12'h004, 32'h5);
      bus_rd(12'h00C, d); check("R2 set 0101", d, 5);
      bus_wr(12'h004, 32'h2);
      bus_rd(12'h00C, d); check("R2 set adds 0010", d, 7);
      bus_wr(12'h004, 32'h0);
      bus_rd(12'h00C, d); check("R2 zero bits no effect", d, 7);
      bus_wr(12'h008, 32'h4);
      bus_rd(12'h00C, d); check("R3 clear 0100", d, 3);
      bus_wr(12'h008, 32'hF);
      bus_rd(12'h00C, d); check("R3 clear all", d, 0);

      // R4 mode encoding and clamp, R5 idle level
      bus_wr(ch_addr(1, 0), 32'h20F);
      bus_rd(ch_addr(1, 0), d); check("R4 select clamp", d, 32'h20A);
      check("R5 stopped inverted idle", pwm[1], 1);
      bus_wr(ch_addr(1, 0), 32'h0);
      check("R5 stopped normal idle", pwm[1], 0);

      // Vector table: R6 R7 R11
      foreach (VECS[i]) begin
         int ch;
         ch = i % 4;
         bus_wr(ch_addr(ch, 0), {22'd0, VECS[i].pol, 5'd0, VECS[i].pres});
         bus_wr(ch_addr(ch, 'h04), {16'd0, VECS[i].duty});
         bus_wr(ch_addr(ch, 'h0C), {16'd0, VECS[i].per});
         bus_wr(12'h004, 32'(1 << ch));
         count_high(ch, int'(VECS[i].win), hi);
         check($sformatf("R6 R7 R11 vector %0d high", i), hi, VECS[i].high);
         bus_wr(12'h008, 32'(1 << ch));
         check($sformatf("R5 vector %0d idle", i), pwm[ch], VECS[i].pol);
         bus_wr(ch_addr(ch, 0), 32'h0);
      end

      // R8 direct writes
      bus_wr(ch_addr(2, 'h04), 32'hABCD0007);
      bus_rd(ch_addr(2, 'h04), d); check("R8 duty low bits", d, 7);
      bus_wr(ch_addr(2, 'h0C), 32'h40);
      bus_rd(ch_addr(2, 'h0C), d); check("R8 period stopped", d, 32'h40);
      bus_wr(12'h004, 32'h4);
      bus_wr(ch_addr(2, 'h04), 32'h11);
      bus_rd(ch_addr(2, 'h04), d); check("R8 duty ignored running", d, 7);
      bus_wr(ch_addr(2, 'h0C), 32'h99);
      bus_rd(ch_addr(2, 'h0C), d); check("R8 period ignored running", d, 32'h40);
      bus_wr(12'h004, 32'h4);
      bus_rd(12'h00C, d); check("R11 re-enable keeps running", d, 4);
      bus_wr(12'h008, 32'h4);
      bus_wr(ch_addr(2, 'h08), 32'h9);
      bus_rd(ch_addr(2, 'h04), d); check("R9 update while stopped", d, 9);

      // R9 buffered duty
      bus_wr(ch_addr(0, 'h04), 32'd2);
      bus_wr(ch_addr(0, 'h0C), 32'd8);
      bus_wr(12'h004, 32'h1);
      bus_wr(ch_addr(0, 'h08), 32'd6);
      bus_rd(ch_addr(0, 'h04), d); check("R9 duty held", d, 2);
      count_high(0, 7, hi); check("R9 rest of cycle old duty", hi, 1);
      count_high(0, 8, hi); check("R9 next cycle new duty", hi, 6);
      bus_rd(ch_addr(0, 'h04), d); check("R9 duty applied", d, 6);
      bus_wr(12'h008, 32'h1);

      // R10 buffered period
      bus_wr(ch_addr(1, 'h04), 32'd3);
      bus_wr(ch_addr(1, 'h0C), 32'd4);
      bus_wr(12'h004, 32'h2);
      bus_wr(ch_addr(1, 'h10), 32'd6);
      bus_rd(ch_addr(1, 'h0C), d); check("R10 period held", d, 4);
      count_high(1, 3, hi); check("R10 rest of old cycle", hi, 2);
      bus_rd(ch_addr(1, 'h0C), d); check("R10 period applied", d, 6);
      count_high(1, 6, hi); check("R10 new cycle", hi, 3);
      bus_wr(12'h008, 32'h2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule